// File: doc/BRIEF.md
# Barrel Shifter and Bit-Field Unit

This block is the shift and bit-manipulation unit of a DSP processing element. In one registered stage it performs logical and arithmetic shifts and rotates by a signed count, where a negative count moves bits toward bit 0. It also sets, clears, toggles and tests single bits, extracts and deposits bit fields, and counts leading sign bits so that an exponent can be derived from a fixed-point value.

Every operation takes an operand, the existing destination value, an opcode and a control word. The control word comes either from a full-width register input or from a short immediate input, chosen per operation. The same low bits of the selected word carry the shift count, the bit index, or a packed position/length pair. A result, a zero flag and an overflow flag appear one clock after the operation is presented.

Top module: `shf_unit`

## Requirements
- R1: Opcode 0 (logical shift) shifts the operand left by a positive count and right by a negative count, filling with zeros. A count whose magnitude is 32 or more gives 0.
- R2: Opcode 1 (arithmetic shift) fills with copies of bit 31 on right shifts and with zeros on left shifts. A right count of magnitude 32 or more gives all copies of bit 31, and a left count of 32 or more gives 0.
- R3: Opcode 2 (rotate) rotates left by the count modulo 32. A negative count therefore rotates right.
- R4: For opcodes 0 and 1 with a positive count, the overflow flag is set when the shifted value, shifted back by the same kind of shift, differs from the operand. Right shifts and rotates never set it.
- R5: Opcode 3 (extract) returns the field of the operand starting at bit `pos` with `len` bits, placed at bit 0 and zero-extended. Any part of the field above bit 31 is dropped, and a length of 0 gives 0.
- R6: Opcode 4 (signed extract) is opcode 3 with the result sign-extended from the highest bit actually extracted.
- R7: Opcode 5 (extract-OR) returns the destination ORed with the zero-extended field of opcode 3.
- R8: Opcode 6 (deposit) takes the low `len` bits of the operand and writes them into the destination starting at bit `pos`. All other destination bits are kept, and bits that would land above bit 31 are dropped.
- R9: For the field opcodes 3 to 6, the overflow flag is set when pos + len exceeds 32.
- R10: Opcodes 7, 8 and 9 set, clear and toggle operand bit `idx`. Opcode 10 (test) returns the destination unchanged and sets the zero flag exactly when operand bit `idx` is 0.
- R11: Opcode 11 returns the number of consecutive bits, counted from bit 31 downward, that equal bit 31 (range 1 to 32). Opcodes 12 to 15 return 0.
- R12: The control word is the register input when `imm_sel_i` is 0 and the zero-extended 12-bit immediate when it is 1. Within it, the signed 8-bit count is bits 7:0, `idx` is bits 4:0, `pos` is bits 5:0 and `len` is bits 11:6. Higher bits are ignored.
- R13: Result and flags are registered and appear in the cycle after `in_valid` is high, with `out_valid_o` high for that cycle. Outputs hold while `in_valid` is low, and reset clears all of them. Except for opcode 10, the zero flag is set when the result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation presented this cycle |
| op_i | input | 4 | Opcode |
| opnd_i | input | 32 | Operand |
| dest_i | input | 32 | Existing destination value |
| ctl_reg_i | input | 32 | Control word from a register |
| ctl_imm_i | input | 12 | Immediate control word |
| imm_sel_i | input | 1 | Select the immediate control word |
| out_valid_o | output | 1 | Result valid |
| result_o | output | 32 | Result |
| zero_o | output | 1 | Zero flag |
| ovf_o | output | 1 | Overflow flag |

## Verification
The bench builds the unit with its default parameters: a 32-bit datapath, an 8-bit signed count and 6-bit position and length fields. The 8-bit count reaches magnitudes up to 128, well beyond the 32 where shifts saturate. The 6-bit position and length let a field run past bit 31, so the truncation and overflow cases of extract and deposit are exercised directly.

// File: rtl/shf_pkg.sv
package shf_pkg;
    typedef enum logic [3:0] {
        OP_LSH   = 4'd0,
        OP_ASH   = 4'd1,
        OP_ROT   = 4'd2,
        OP_XTR   = 4'd3,
        OP_XTRSE = 4'd4,
        OP_XTROR = 4'd5,
        OP_DEP   = 4'd6,
        OP_BSET  = 4'd7,
        OP_BCLR  = 4'd8,
        OP_BTGL  = 4'd9,
        OP_BTST  = 4'd10,
        OP_LEAD  = 4'd11
    } shf_op_e;
endpackage

// File: rtl/shf_ctl_sel.sv
module shf_ctl_sel #(
    parameter int W  = 32,
    parameter int CW = 8,
    parameter int PW = 6
) (
    input  logic [W-1:0]         ctl_reg,
    input  logic [2*PW-1:0]      ctl_imm,
    input  logic                 imm_sel,
    output logic signed [CW-1:0] cnt,
    output logic [PW-1:0]        pos,
    output logic [PW-1:0]        len,
    output logic [$clog2(W)-1:0] idx
);
    localparam int IW = $clog2(W);
    logic [W-1:0] sel;

    always_comb begin
        sel = imm_sel ? W'(ctl_imm) : ctl_reg;
        cnt = sel[CW-1:0];
        pos = sel[PW-1:0];
        len = sel[2*PW-1:PW];
        idx = sel[IW-1:0];
    end

    logic unused_hi;
    assign unused_hi = ^sel[W-1:2*PW];
endmodule

// File: rtl/shf_shift.sv
module shf_shift #(
    parameter int W  = 32,
    parameter int CW = 8
) (
    input  logic [W-1:0]         a,
    input  logic signed [CW-1:0] cnt,
    input  logic [1:0]           mode,
    output logic [W-1:0]         res,
    output logic                 ovf
);
    localparam int IW = $clog2(W);
    localparam logic [1:0] M_LSH = 2'd0;
    localparam logic [1:0] M_ASH = 2'd1;

    logic          neg;
    logic          big;
    logic [CW-1:0] mag;
    logic [IW-1:0] sh;
    logic [W-1:0]  back;
    logic [2*W-1:0] rot2;

    always_comb begin
        neg  = cnt[CW-1];
        mag  = neg ? (~cnt + CW'(1)) : cnt;
        big  = int'(mag) >= W;
        sh   = mag[IW-1:0];
        rot2 = {a, a} << cnt[IW-1:0];
        res  = '0;
        if (mode == M_LSH || mode == M_ASH) begin
            if (neg) begin
                if (mode == M_ASH) begin
                    if (big) res = {W{a[W-1]}};
                    else     res = $signed(a) >>> sh;
                end else begin
                    if (!big) res = a >> sh;
                end
            end else if (!big) begin
                res = a << sh;
            end
        end else begin
            res = rot2[2*W-1:W];
        end
        if (mode == M_ASH) back = $signed(res) >>> sh;
        else               back = res >> sh;
        ovf = 1'b0;
        if ((mode == M_LSH || mode == M_ASH) && !neg)
            ovf = big ? (a != '0) : (back != a);
    end
endmodule

// File: rtl/shf_field.sv
module shf_field #(
    parameter int W  = 32,
    parameter int PW = 6
) (
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  dest,
    input  logic [PW-1:0] pos,
    input  logic [PW-1:0] len,
    input  logic [1:0]    mode,
    output logic [W-1:0]  res,
    output logic          ovf
);
    localparam logic [PW:0] WX = (PW+1)'(W);

    logic [PW:0]  posx, lenx, room, elen, sum;
    logic [W-1:0] mask_e, fld, dmask, pmask, placed, sfill;
    logic         sgn;

    always_comb begin
        posx  = {1'b0, pos};
        lenx  = {1'b0, len};
        sum   = posx + lenx;
        ovf   = sum > WX;
        room  = WX - posx;
        if (posx >= WX)       elen = '0;
        else if (lenx < room) elen = lenx;
        else                  elen = room;
        mask_e = ~({W{1'b1}} << elen);
        fld    = (a >> pos) & mask_e;
        sgn    = (elen != '0) ? fld[elen - (PW+1)'(1)] : 1'b0;
        sfill  = sgn ? ~mask_e : '0;
        dmask  = ~({W{1'b1}} << len);
        pmask  = dmask << pos;
        placed = (a & dmask) << pos;
        case (mode)
            2'd0:    res = fld;
            2'd1:    res = fld | sfill;
            2'd2:    res = dest | fld;
            default: res = (dest & ~pmask) | placed;
        endcase
    end
endmodule

// File: rtl/shf_bit.sv
module shf_bit #(
    parameter int W = 32
) (
    input  logic [W-1:0]         a,
    input  logic [$clog2(W)-1:0] idx,
    input  logic [1:0]           mode,
    output logic [W-1:0]         res,
    output logic                 tst_zero
);
    localparam int IW = $clog2(W);

    logic [W-1:0] onehot;
    logic [IW:0]  lc;
    logic         run;

    always_comb begin
        onehot   = W'(1) << idx;
        tst_zero = ~a[idx];
        lc  = '0;
        run = 1'b1;
        for (int i = W-1; i >= 0; i--) begin
            if (run && (a[i] == a[W-1])) lc = lc + (IW+1)'(1);
            else                         run = 1'b0;
        end
        case (mode)
            2'd0:    res = a | onehot;
            2'd1:    res = a & ~onehot;
            2'd2:    res = a ^ onehot;
            default: res = W'(lc);
        endcase
    end
endmodule

// File: rtl/shf_unit.sv
module shf_unit
    import shf_pkg::*;
#(
    parameter int W  = 32,
    parameter int CW = 8,
    parameter int PW = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [3:0]      op_i,
    input  logic [W-1:0]    opnd_i,
    input  logic [W-1:0]    dest_i,
    input  logic [W-1:0]    ctl_reg_i,
    input  logic [2*PW-1:0] ctl_imm_i,
    input  logic            imm_sel_i,
    output logic            out_valid_o,
    output logic [W-1:0]    result_o,
    output logic            zero_o,
    output logic            ovf_o
);
    localparam int IW = $clog2(W);

    typedef struct packed {
        logic         vld;
        logic [W-1:0] res;
        logic         zf;
        logic         of;
    } st_t;

    st_t st_d, st_q;
    shf_op_e op_e;

    logic signed [CW-1:0] cnt;
    logic [PW-1:0]        pos, len;
    logic [IW-1:0]        idx;
    logic [W-1:0]         sh_res, fd_res, bt_res;
    logic                 sh_ovf, fd_ovf, bt_tz;
    logic [1:0]           sh_mode, fd_mode, bt_mode;

    assign op_e = shf_op_e'(op_i);

    shf_ctl_sel #(.W(W), .CW(CW), .PW(PW)) u_sel (
        .ctl_reg(ctl_reg_i), .ctl_imm(ctl_imm_i), .imm_sel(imm_sel_i),
        .cnt(cnt), .pos(pos), .len(len), .idx(idx)
    );

    shf_shift #(.W(W), .CW(CW)) u_shift (
        .a(opnd_i), .cnt(cnt), .mode(sh_mode), .res(sh_res), .ovf(sh_ovf)
    );

    shf_field #(.W(W), .PW(PW)) u_field (
        .a(opnd_i), .dest(dest_i), .pos(pos), .len(len), .mode(fd_mode),
        .res(fd_res), .ovf(fd_ovf)
    );

    shf_bit #(.W(W)) u_bit (
        .a(opnd_i), .idx(idx), .mode(bt_mode), .res(bt_res), .tst_zero(bt_tz)
    );

    always_comb begin
        sh_mode = (op_e == OP_ASH) ? 2'd1 : (op_e == OP_ROT) ? 2'd2 : 2'd0;
        case (op_e)
            OP_XTRSE: fd_mode = 2'd1;
            OP_XTROR: fd_mode = 2'd2;
            OP_DEP:   fd_mode = 2'd3;
            default:  fd_mode = 2'd0;
        endcase
        case (op_e)
            OP_BCLR: bt_mode = 2'd1;
            OP_BTGL: bt_mode = 2'd2;
            OP_LEAD: bt_mode = 2'd3;
            default: bt_mode = 2'd0;
        endcase

        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.of = 1'b0;
            case (op_e)
                OP_LSH, OP_ASH, OP_ROT: begin
                    st_d.res = sh_res;
                    st_d.of  = sh_ovf;
                end
                OP_XTR, OP_XTRSE, OP_XTROR, OP_DEP: begin
                    st_d.res = fd_res;
                    st_d.of  = fd_ovf;
                end
                OP_BSET, OP_BCLR, OP_BTGL, OP_LEAD: st_d.res = bt_res;
                OP_BTST: st_d.res = dest_i;
                default: st_d.res = '0;
            endcase
            st_d.zf = (op_e == OP_BTST) ? bt_tz : (st_d.res == '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid_o = st_q.vld;
    assign result_o    = st_q.res;
    assign zero_o      = st_q.zf;
    assign ovf_o       = st_q.of;

    p_valid_rise_r13: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid_o);
    p_valid_fall_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid_o);
    p_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result_o));
    p_big_lsh_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_i == OP_LSH && ($signed(cnt) >= W || $signed(cnt) <= -W))
        |=> result_o == '0);
    p_big_ash_sign_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_i == OP_ASH && $signed(cnt) <= -W)
        |=> result_o == {W{$past(opnd_i[W-1])}});
    p_btst_dest_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_i == OP_BTST) |=> result_o == $past(dest_i));
    p_lead_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_i == OP_LEAD) |=> (result_o >= W'(1) && result_o <= W'(W)));
    p_fld_ovf_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_i == OP_XTR && (int'(pos) + int'(len) <= W)) |=> !ovf_o);
endmodule

// File: tb/shf_unit_tb.sv
`timescale 1ns/1ps
module shf_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op = '0;
    logic [31:0] opnd = '0, dest = '0, ctl = '0;
    logic [11:0] imm = '0;
    logic        isel = 1'b0;
    logic        ov, zf, of;
    logic [31:0] res;
    int n_chk = 0, n_bad = 0;
    bit  done = 0;

    always #2 clk = ~clk;

    shf_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_i(op),
        .opnd_i(opnd), .dest_i(dest), .ctl_reg_i(ctl), .ctl_imm_i(imm),
        .imm_sel_i(isel), .out_valid_o(ov), .result_o(res), .zero_o(zf),
        .ovf_o(of)
    );

    task automatic ck(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive at a falling edge, sample at the next falling edge (one register)
    task automatic run(input logic [3:0] o, input logic [31:0] a, input logic [31:0] c,
                       input logic [31:0] d, input logic s, input logic [11:0] im);
        op = o; opnd = a; ctl = c; dest = d; isel = s; imm = im; in_valid = 1'b1;
        @(negedge clk);
    endtask

    task automatic exp3(input string tag, input logic [31:0] r, input logic z, input logic v);
        ck({tag, " result"}, res, r);
        ck({tag, " zero"}, {31'b0, zf}, {31'b0, z});
        ck({tag, " ovf"}, {31'b0, of}, {31'b0, v});
        ck({tag, " valid"}, {31'b0, ov}, 32'd1);
    endtask

    task automatic t_reset;
        ck("R13 reset valid", {31'b0, ov}, 32'd0);
        ck("R13 reset result", res, 32'd0);
        ck("R13 reset flags", {30'b0, zf, of}, 32'd0);
    endtask

    task automatic t_logical;
        run(4'd0, 32'h0000_00F1, 32'hABCD_0004, 0, 0, 0); exp3("R1 lsh left 4", 32'h0000_0F10, 0, 0);
        run(4'd0, 32'hFF00_0000, 32'h0000_00F8, 0, 0, 0); exp3("R1 lsh right 8", 32'h00FF_0000, 0, 0);
        run(4'd0, 32'hFF00_0000, 32'h0000_0028, 0, 0, 0); exp3("R1 lsh left 40", 32'h0, 1, 1);
        run(4'd0, 32'hFF00_0000, 32'h0000_00E0, 0, 0, 0); exp3("R1 lsh right 32", 32'h0, 1, 0);
    endtask

    task automatic t_arith;
        run(4'd1, 32'hFF00_0000, 32'h0000_00F8, 0, 0, 0); exp3("R2 ash right 8", 32'hFFFF_0000, 0, 0);
        run(4'd1, 32'hFF00_0000, 32'h0000_009C, 0, 0, 0); exp3("R2 ash right 100", 32'hFFFF_FFFF, 0, 0);
        run(4'd1, 32'h4000_0000, 32'h0000_00FD, 0, 0, 0); exp3("R2 ash right 3 pos", 32'h0800_0000, 0, 0);
        run(4'd1, 32'h0000_0003, 32'h0000_0002, 0, 0, 0); exp3("R2 ash left 2", 32'h0000_000C, 0, 0);
    endtask

    task automatic t_overflow;
        run(4'd0, 32'h8000_0001, 32'h1, 0, 0, 0); exp3("R4 lsh lost bit", 32'h0000_0002, 0, 1);
        run(4'd1, 32'h4000_0000, 32'h1, 0, 0, 0); exp3("R4 ash sign change", 32'h8000_0000, 0, 1);
        run(4'd1, 32'hFFFF_FFFF, 32'h4, 0, 0, 0); exp3("R4 ash neg kept", 32'hFFFF_FFF0, 0, 0);
    endtask

    task automatic t_rotate;
        run(4'd2, 32'h8000_0001, 32'h04, 0, 0, 0); exp3("R3 rot left 4", 32'h0000_0018, 0, 0);
        run(4'd2, 32'h8000_0001, 32'hFC, 0, 0, 0); exp3("R3 rot right 4", 32'h1800_0000, 0, 0);
        run(4'd2, 32'h8000_0001, 32'h24, 0, 0, 0); exp3("R3 rot 36 mod 32", 32'h0000_0018, 0, 0);
    endtask

    task automatic t_extract;
        run(4'd3, 32'h00FF_0000, 32'h210, 0, 0, 0); exp3("R5 xtr 16:8", 32'h0000_00FF, 0, 0);
        run(4'd3, 32'hF000_0000, 32'h21C, 0, 0, 0); exp3("R5 R9 xtr past top", 32'h0000_000F, 0, 1);
        run(4'd3, 32'h00FF_0000, 32'h010, 0, 0, 0); exp3("R5 xtr len 0", 32'h0, 1, 0);
        run(4'd4, 32'h00FF_0000, 32'h210, 0, 0, 0); exp3("R6 xtr se neg", 32'hFFFF_FFFF, 0, 0);
        run(4'd4, 32'h007F_0000, 32'h210, 0, 0, 0); exp3("R6 xtr se pos", 32'h0000_007F, 0, 0);
        run(4'd4, 32'hF000_0000, 32'h21C, 0, 0, 0); exp3("R6 xtr se trunc", 32'hFFFF_FFFF, 0, 1);
        run(4'd5, 32'h00AB_0000, 32'h210, 32'h1234_0000, 0, 0); exp3("R7 xtr or", 32'h1234_00AB, 0, 0);
    endtask

    task automatic t_deposit;
        run(4'd6, 32'h0000_00AB, 32'h208, 32'hFFFF_FFFF, 0, 0); exp3("R8 dep 8:8", 32'hFFFF_ABFF, 0, 0);
        run(4'd6, 32'h0000_00AB, 32'h21C, 32'h0, 0, 0); exp3("R8 R9 dep past top", 32'hB000_0000, 0, 1);
    endtask

    task automatic t_bits;
        run(4'd7, 32'h0, 32'd31, 0, 0, 0); exp3("R10 bset 31", 32'h8000_0000, 0, 0);
        run(4'd8, 32'hFFFF_FFFF, 32'd0, 0, 0, 0); exp3("R10 bclr 0", 32'hFFFF_FFFE, 0, 0);
        run(4'd9, 32'h0000_0010, 32'd4, 0, 0, 0); exp3("R10 btgl 4", 32'h0, 1, 0);
        run(4'd10, 32'h0000_0004, 32'd2, 32'h55, 0, 0); exp3("R10 btst set", 32'h55, 0, 0);
        run(4'd10, 32'h0000_0004, 32'd3, 32'h55, 0, 0); exp3("R10 btst clear", 32'h55, 1, 0);
    endtask

    task automatic t_lead;
        run(4'd11, 32'h00FF_FFFF, 0, 0, 0, 0); exp3("R11 lead zeros 8", 32'd8, 0, 0);
        run(4'd11, 32'hFFFF_FFFF, 0, 0, 0, 0); exp3("R11 lead all ones", 32'd32, 0, 0);
        run(4'd11, 32'hC000_0000, 0, 0, 0, 0); exp3("R11 lead ones 2", 32'd2, 0, 0);
        run(4'd11, 32'h8000_0000, 0, 0, 0, 0); exp3("R11 lead ones 1", 32'd1, 0, 0);
        run(4'd13, 32'h1234_5678, 0, 0, 0, 0); exp3("R11 unused opcode", 32'h0, 1, 0);
    endtask

    task automatic t_imm;
        run(4'd3, 32'h00FF_0000, 32'hFFFF_FFFF, 0, 1, 12'h210); exp3("R12 imm field", 32'h0000_00FF, 0, 0);
        run(4'd0, 32'hFF00_0000, 32'h0000_0004, 0, 1, 12'h0F8); exp3("R12 imm count", 32'h00FF_0000, 0, 0);
    endtask

    task automatic t_idle;
        in_valid = 1'b0; opnd = 32'hDEAD_BEEF;
        @(negedge clk);
        ck("R13 valid drops", {31'b0, ov}, 32'd0);
        ck("R13 result held", res, 32'h00FF_0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_logical;
        t_arith;
        t_overflow;
        t_rotate;
        t_extract;
        t_deposit;
        t_bits;
        t_lead;
        t_imm;
        t_idle;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule